// File: doc/BRIEF.md
# DMA Descriptor Staging Queue

This block collects an eight-word extended DMA descriptor from a memory-mapped write port, one 32-bit word per write, into a set of staging registers. Nothing enters the queue until software writes the last word, the control word, with its go bit (bit 31) set. On that write, the seven staged words and the newly written control word move together into a descriptor FIFO as one 256-bit entry. The head entry is offered to a downstream read/write master, which takes it with a pop strobe.

Word slots by write address are: 0 source address low, 1 destination address low, 2 byte count, 3 burst and sequence (write burst 31:24, read burst 23:16, sequence 15:0, a burst of 0 meaning the longest burst), 4 stride (write 31:16, read 15:0, 1 meaning incrementing), 5 source address high, 6 destination address high, 7 control. Control carries the channel in 7:0, start/end-of-packet generation in bits 8 and 9, read/write parking in bits 10 and 11, end-on-packet-end and end-on-length in bits 12 and 13, completion and early-termination interrupt enables in bits 14 and 15, an error interrupt mask in 23:16, early done in bit 24 and go in bit 31. The block stores these words unchanged and never interprets them. Word i of an entry sits at bits 32*i+31 down to 32*i of the head output.

The block reports full, empty, a 16-bit fill level and a sticky overflow flag. Software must not commit while full is high. A commit made while full is high is discarded and raises overflow.

Top module: `dma_desc_stager`

## Requirements
- R1: After reset, empty is 1, full is 0, level is 0 and overflow is 0.
- R2: A write to addresses 0 to 6, or to address 7 with bit 31 clear, updates staging only and leaves level unchanged.
- R3: A write to address 7 with bit 31 set, while full is 0, appends an entry of staged words 0 to 6 plus the written control word. Level rises by one after that edge, and the entry is at the head if the queue was empty.
- R4: Staged words are kept after a commit, so a later commit that rewrites only the control word reuses them.
- R5: Entries leave in the order they were committed. A pop with the queue non-empty removes the head and lowers level by one.
- R6: A pop while empty is ignored: level stays 0 and empty stays 1.
- R7: A commit and a pop in the same cycle on a non-empty, non-full queue leave level unchanged.
- R8: A commit while full is 1 is dropped, leaves the stored entries unchanged and sets overflow.
- R9: Overflow stays set until reset.
- R10: Full is 1 exactly when level equals DEPTH (default 16). Empty is 1 exactly when level is 0. Level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 3 | Word slot, 7 is control |
| wr_data | input | 32 | Word value |
| pop | input | 1 | Downstream takes the head entry |
| head_desc | output | 256 | Head entry, word i at bits 32*i+31:32*i |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| level | output | 16 | Number of stored entries |
| overflow | output | 1 | Sticky: a commit was dropped while full |

## Verification
The bench targets several specific mistakes:
- A control write with go clear must push nothing. A design that pushed on any control write would show a level rise.
- A commit must carry the control value written in that same cycle. A design that took the old staged control would show a stale word 7 at the head.
- After a commit that rewrites only control, the other words must be kept. A design that cleared staging on commit would show zeros in words 0 to 6.
- At the full boundary, the bench commits while full, and also commits and pops together while full. A design that let the write through would corrupt the head, raise the level or wrap the pointers.
- The bench pops an empty queue and pushes and pops in one cycle, looking for off-by-one errors in the level.

// File: rtl/dma_desc_stager.sv
module dma_desc_stager #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 16,
  parameter int WORDS = 8,
  parameter int WW    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_addr,
  input  logic [WW-1:0]          wr_data,
  input  logic                   pop,
  output logic [WORDS*WW-1:0]    head_desc,
  output logic                   full,
  output logic                   empty,
  output logic [LVL_W-1:0]       level,
  output logic                   overflow
);
  localparam int DW   = WORDS * WW;
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CTRL = WORDS - 1;
  localparam int GO   = WW - 1;

  logic [WW-1:0]    stage [CTRL];
  logic [DW-1:0]    mem   [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [LVL_W-1:0] cnt;
  logic [DW-1:0]    entry;
  logic             commit, do_push, do_pop;

  assign commit  = wr_en && (wr_addr == 3'(CTRL)) && wr_data[GO];
  assign do_push = commit && !full;
  assign do_pop  = pop && !empty;

  for (genvar i = 0; i < CTRL; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)                           stage[i] <= '0;
      else if (wr_en && wr_addr == 3'(i))   stage[i] <= wr_data;
    end
    assign entry[i*WW +: WW] = stage[i];
  end
  assign entry[CTRL*WW +: WW] = wr_data;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      cnt <= cnt + LVL_W'(1);
      else if (do_pop && !do_push) cnt <= cnt - LVL_W'(1);
      if (commit && full) overflow <= 1'b1;
    end
  end

  assign head_desc = mem[rp];
  assign level     = cnt;
  assign empty     = (cnt == '0);
  assign full      = (cnt == LVL_W'(DEPTH));
endmodule

// File: rtl/dma_desc_stager_chk.sv
module dma_desc_stager_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 16,
  parameter int WW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [WW-1:0]    wr_data,
  input logic             pop,
  input logic             full,
  input logic             empty,
  input logic [LVL_W-1:0] level,
  input logic             overflow
);
  logic go_wr;
  assign go_wr = wr_en && (wr_addr == 3'd7) && wr_data[WW-1];

  AST_NO_GO_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_wr && !pop) |=> level == $past(level)); // R2
  AST_COMMIT_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !full && !pop) |=> level == $past(level) + LVL_W'(1)); // R3
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !go_wr) |=> empty); // R6
  AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && pop && !full && !empty) |=> $stable(level)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && full && !pop) |=> (level == $past(level)) && overflow); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R10
endmodule

bind dma_desc_stager dma_desc_stager_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pop(pop), .full(full), .empty(empty), .level(level), .overflow(overflow));

// File: tb/tb_dma_desc_stager.sv
`timescale 1ns/1ps
module tb_dma_desc_stager;
  localparam int DEPTH = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, pop = 0;
  logic [2:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [255:0] head_desc;
  logic full, empty, overflow;
  logic [15:0] level;
  int total = 0, bad = 0;

  logic [255:0] mq[$];
  logic [31:0] mstg[7];
  bit mov;

  always #2 clk = ~clk;

  dma_desc_stager dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pop(pop), .head_desc(head_desc), .full(full), .empty(empty),
    .level(level), .overflow(overflow));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int n = mq.size();
    chk(level == 16'(n), tag, "level", 256'(level), 256'(n));
    chk(empty == (n == 0), tag, "empty", 256'(empty), 256'(n == 0));
    chk(full == (n == DEPTH), tag, "full", 256'(full), 256'(n == DEPTH));
    chk(overflow == mov, tag, "overflow", 256'(overflow), 256'(mov));
    if (n > 0) chk(head_desc == mq[0], tag, "head", head_desc, mq[0]);
  endtask

  task automatic model_reset();
    mq.delete();
    mov = 0;
    for (int i = 0; i < 7; i++) mstg[i] = '0;
  endtask

  task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d,
                      input bit p, input string tag);
    bit commit, pushok, popok;
    logic [255:0] e;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; pop = p;
    @(posedge clk);
    commit = we && a == 3'd7 && d[31];
    pushok = commit && mq.size() < DEPTH;
    popok  = p && mq.size() > 0;
    for (int i = 0; i < 7; i++) e[i*32 +: 32] = mstg[i];
    e[255:224] = d;
    if (we && a != 3'd7) mstg[a] = d;
    if (commit && !pushok) mov = 1;
    if (popok) void'(mq.pop_front());
    if (pushok) mq.push_back(e);
    #1;
    compare(tag);
  endtask

  task automatic load(input logic [31:0] base, input string tag);
    for (int i = 0; i < 7; i++) step(1, 3'(i), base + 32'(i), 0, tag);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 compare("R1");
    load(32'hA000_0000, "R2");
    step(1, 3'd7, 32'h0000_4301, 0, "R2");
    step(1, 3'd7, 32'h8000_6302, 0, "R3");
    step(1, 3'd7, 32'h8001_0003, 0, "R4");
    step(0, 3'd0, 0, 1, "R5");
    step(0, 3'd0, 0, 1, "R5");
    step(0, 3'd0, 0, 1, "R6");
    step(0, 3'd0, 0, 1, "R6");
    for (int k = 0; k < DEPTH; k++) begin
      step(1, 3'd2, 32'h100 + 32'(k), 0, "R4");
      step(1, 3'd7, 32'h8000_0000 | 32'(k), 0, "R10");
    end
    step(1, 3'd3, 32'hDEAD_BEEF, 0, "R8");
    step(1, 3'd7, 32'h8000_00FF, 0, "R8");
    step(1, 3'd7, 32'h8000_00FE, 1, "R8");
    step(1, 3'd7, 32'h8000_0077, 1, "R7");
    step(1, 3'd7, 32'h8000_0078, 1, "R7");
    for (int k = 0; k < DEPTH + 2; k++) step(0, 3'd0, 0, 1, "R9");
    load(32'hC000_0000, "R2");
    step(1, 3'd7, 32'h8000_0011, 0, "R3");
    step(1, 3'd7, 32'h8000_0012, 1, "R7");
    step(1, 3'd7, 32'h0000_0013, 1, "R5");
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    model_reset();
    #1 compare("R9");
    step(1, 3'd7, 32'h8000_0021, 0, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule